// File: doc/BRIEF.md
# Weighted byte-quota ring scheduler

This block decides which of eight transmit rings may send its next frame. In the weighted mode, each ring gets a byte allowance for every scheduling round. The allowance is the ring's 8-bit weight multiplied by 64 bytes. The block visits the rings from the lowest index upward. A ring keeps the grant while it still has allowance left and is still requesting. Each time a frame is sent, a report of its byte count is subtracted from the granted ring's allowance. When no ring still to be visited can be served, the round closes with a one-cycle pulse, every allowance is refilled and the visit restarts at ring 0.

The other three mode codes select a plain fixed-priority arbiter that ignores the weights. The grant is combinational from the current requests, weights, mode and internal state. A transmit engine can therefore sample it in the same cycle and return a byte report while it holds the grant.

Top module: `wrr_quota_sched`

## Requirements
- R1: While `rst_n` is low, `grant_o` is all zeros and `round_done_o` is low.
- R2: Weighted scheduling is in force only when `mode_i` equals 2'b10. For 2'b00, 2'b01 and 2'b11, `grant_o` has one bit set: the lowest-index set bit of `req_i`. Weights play no part in these modes, and `round_done_o` stays low.
- R3: In weighted mode, each ring's allowance is refilled to weight × 64 bytes at a round boundary. A granted ring keeps the grant while it requests and its allowance is above zero. A frame larger than the remaining allowance is still accepted and leaves the allowance at zero.
- R4: In weighted mode, a ring whose weight field (bits 8i+7..8i of `weight_i` for ring i) is zero is never granted.
- R5: Within a round, the grant never moves to a lower-index ring. A ring that drops its request while holding allowance loses the grant. It cannot be granted again until the next round if a higher ring has been granted since.
- R6: When no ring at or above the current ring can be served, and at least one grant was given in the round, `round_done_o` pulses for one cycle with `grant_o` zero. All allowances then refill and the next round starts from ring 0. A weighted cycle with no round in progress gives no pulse.
- R7: `grant_o` (bit i = ring i) never has more than one bit set. It is zero when no ring is eligible.
- R8: A byte report (`sent_valid_i` high) reduces only the allowance of the ring granted in that cycle. The other rings' allowances are unchanged.
- R9: Any cycle spent outside weighted mode abandons the round in progress. On return to weighted mode, scheduling restarts from ring 0 with full allowances and no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Scheduling mode; 2'b10 selects weighted rounds |
| req_i | input | 8 | Per-ring send request, bit i for ring i |
| weight_i | input | 64 | Per-ring weight in 64-byte units, ring i in bits 8i+7..8i |
| sent_valid_i | input | 1 | A frame of the granted ring was sent this cycle |
| sent_bytes_i | input | 16 | Byte count of that frame |
| grant_o | output | 8 | One-hot grant, zero when no ring is eligible |
| round_done_o | output | 1 | One-cycle pulse when a weighted round closes |

## Verification
The assertions assume that a byte report arrives only in a cycle where the grant is held, and that it belongs to the granted ring. They also assume that weights are not changed in the middle of a round when the allowance figures matter. The stimulus keeps to both assumptions. It raises `sent_valid_i` only on steps where the expected grant is nonzero, and it rewrites the weights only on cycles where the block refills its allowances. The single exception is the all-zero-weight step, which relies only on the weight test in eligibility.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;

  localparam logic [1:0] MODE_WEIGHTED = 2'b10;

  // Allowance for one round: weight units of 2**unit_lg bytes.
  function automatic int unsigned quota_bytes(input int unsigned weight,
                                              input int unsigned unit_lg);
    return weight << unit_lg;
  endfunction

  // Allowance left after a frame; a frame that overshoots leaves zero.
  function automatic int unsigned charge(input int unsigned left,
                                         input int unsigned bytes);
    int unsigned rest;
    rest = (bytes >= left) ? 0 : left - bytes;
    return rest;
  endfunction

  // Position of the lowest set bit (0 when none).
  function automatic int unsigned first_set(input logic [63:0] v);
    int unsigned pos;
    pos = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) pos = unsigned'(i);
    end
    return pos;
  endfunction

endpackage

// File: rtl/wrr_lowest_pick.sv
module wrr_lowest_pick #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] cand_i,
  input  logic [IDX_W-1:0] floor_i,
  output logic [WIDTH-1:0] onehot_o,
  output logic             any_o
);

  // Lowest candidate whose index is not below floor_i.
  always_comb begin
    onehot_o = '0;
    any_o    = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (cand_i[i] && (i >= int'(floor_i))) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        any_o       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wrr_deficit_bank.sv
module wrr_deficit_bank
  import wrr_sched_pkg::*;
#(
  parameter int RINGS    = 8,
  parameter int WEIGHT_W = 8,
  parameter int UNIT_LG  = 6,
  parameter int BYTES_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [RINGS*WEIGHT_W-1:0] weights_i,
  input  logic                      reload_i,
  input  logic                      charge_en_i,
  input  logic [RINGS-1:0]          charge_sel_i,
  input  logic [BYTES_W-1:0]        bytes_i,
  output logic [RINGS-1:0]          has_quota_o
);

  localparam int CNT_W = WEIGHT_W + UNIT_LG;

  for (genvar g = 0; g < RINGS; g++) begin : g_ring
    logic [WEIGHT_W-1:0] wt;
    logic [CNT_W-1:0]    left_q;

    assign wt = weights_i[g*WEIGHT_W +: WEIGHT_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        left_q <= '0;
      end else if (reload_i) begin
        left_q <= CNT_W'(quota_bytes(32'(wt), unsigned'(UNIT_LG)));
      end else if (charge_en_i && charge_sel_i[g]) begin
        left_q <= CNT_W'(charge(32'(left_q), 32'(bytes_i)));
      end
    end

    assign has_quota_o[g] = |left_q;
  end

endmodule

// File: rtl/wrr_quota_sched.sv
module wrr_quota_sched
  import wrr_sched_pkg::*;
#(
  parameter int RINGS    = 8,
  parameter int WEIGHT_W = 8,
  parameter int UNIT_LG  = 6,
  parameter int BYTES_W  = 16,
  localparam int IDX_W   = (RINGS > 1) ? $clog2(RINGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode_i,
  input  logic [RINGS-1:0]          req_i,
  input  logic [RINGS*WEIGHT_W-1:0] weight_i,
  input  logic                      sent_valid_i,
  input  logic [BYTES_W-1:0]        sent_bytes_i,
  output logic [RINGS-1:0]          grant_o,
  output logic                      round_done_o
);

  // Named internal events, observed by the bound checker.
  logic [IDX_W-1:0] ptr_q;        // ring the sweep has reached
  logic             active_q;     // a grant was given in this round
  logic             wrr_mode;
  logic [RINGS-1:0] has_quota;
  logic [RINGS-1:0] eligible;
  logic [RINGS-1:0] wrr_oh;
  logic             wrr_any;
  logic [RINGS-1:0] fix_oh;
  logic             fix_any;
  logic             sweep_end;
  logic             reload;
  logic             charge_en;

  assign wrr_mode = (mode_i == MODE_WEIGHTED);

  for (genvar g = 0; g < RINGS; g++) begin : g_elig
    assign eligible[g] = req_i[g] && has_quota[g] &&
                         (|weight_i[g*WEIGHT_W +: WEIGHT_W]);
  end

  wrr_lowest_pick #(.WIDTH(RINGS)) u_wrr_pick (
    .cand_i   (eligible),
    .floor_i  (ptr_q),
    .onehot_o (wrr_oh),
    .any_o    (wrr_any)
  );

  wrr_lowest_pick #(.WIDTH(RINGS)) u_fix_pick (
    .cand_i   (req_i),
    .floor_i  ('0),
    .onehot_o (fix_oh),
    .any_o    (fix_any)
  );

  assign sweep_end = !wrr_any;
  assign reload    = !wrr_mode || sweep_end;
  assign charge_en = wrr_mode && wrr_any && sent_valid_i;

  wrr_deficit_bank #(
    .RINGS    (RINGS),
    .WEIGHT_W (WEIGHT_W),
    .UNIT_LG  (UNIT_LG),
    .BYTES_W  (BYTES_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .weights_i    (weight_i),
    .reload_i     (reload),
    .charge_en_i  (charge_en),
    .charge_sel_i (wrr_oh),
    .bytes_i      (sent_bytes_i),
    .has_quota_o  (has_quota)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      active_q <= 1'b0;
    end else if (reload) begin
      ptr_q    <= '0;
      active_q <= 1'b0;
    end else begin
      ptr_q    <= IDX_W'(first_set(64'(wrr_oh)));
      active_q <= 1'b1;
    end
  end

  always_comb begin
    grant_o      = '0;
    round_done_o = 1'b0;
    if (rst_n) begin
      if (wrr_mode) begin
        grant_o      = wrr_oh;
        round_done_o = sweep_end && active_q;
      end else if (fix_any) begin
        grant_o = fix_oh;
      end
    end
  end

endmodule

// File: rtl/wrr_quota_sched_chk.sv
module wrr_quota_sched_chk
  import wrr_sched_pkg::*;
#(
  parameter int RINGS    = 8,
  parameter int WEIGHT_W = 8,
  parameter int IDX_W    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                mode_i,
  input logic [RINGS-1:0]          req_i,
  input logic [RINGS*WEIGHT_W-1:0] weight_i,
  input logic [RINGS-1:0]          grant_o,
  input logic                      round_done_o,
  input logic [IDX_W-1:0]          ptr_q,
  input logic                      active_q
);

  logic [RINGS-1:0] zero_mask;
  logic [IDX_W-1:0] grant_idx;

  always_comb begin
    zero_mask = '0;
    grant_idx = '0;
    for (int i = 0; i < RINGS; i++) begin
      zero_mask[i] = (weight_i[i*WEIGHT_W +: WEIGHT_W] == '0);
      if (grant_o[i]) grant_idx = IDX_W'(i);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (grant_o == '0 && !round_done_o));

  assert_onehot_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_zero_weight_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_WEIGHTED) |-> ((grant_o & zero_mask) == '0));

  assert_fixed_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_WEIGHTED) |-> (grant_o == (req_i & (~req_i + RINGS'(1)))));

  assert_pulse_only_weighted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    round_done_o |-> (mode_i == MODE_WEIGHTED));

  assert_no_backstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_WEIGHTED) && grant_o != '0) |-> (grant_idx >= ptr_q));

  assert_pulse_idle_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    round_done_o |-> (grant_o == '0 && active_q));

  assert_round_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    round_done_o |=> (ptr_q == '0 && !active_q));

  assert_mode_abandon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_WEIGHTED) |=> (ptr_q == '0 && !active_q));

endmodule

bind wrr_quota_sched wrr_quota_sched_chk #(
  .RINGS    (RINGS),
  .WEIGHT_W (WEIGHT_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .req_i        (req_i),
  .weight_i     (weight_i),
  .grant_o      (grant_o),
  .round_done_o (round_done_o),
  .ptr_q        (ptr_q),
  .active_q     (active_q)
);

// File: tb/wrr_quota_sched_test.sv
`timescale 1ns/1ps
module wrr_quota_sched_test;

  localparam int RINGS = 8;
  localparam int WW    = 8;
  localparam int BW    = 16;
  localparam logic [1:0] WM = 2'b10;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic               rst_n = 1'b0;
  logic [1:0]         mode_i = 2'b00;
  logic [RINGS-1:0]   req_i = '0;
  logic [RINGS*WW-1:0] weight_i = '0;
  logic               sent_valid_i = 1'b0;
  logic [BW-1:0]      sent_bytes_i = '0;
  logic [RINGS-1:0]   grant_o;
  logic               round_done_o;

  wrr_quota_sched uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .req_i        (req_i),
    .weight_i     (weight_i),
    .sent_valid_i (sent_valid_i),
    .sent_bytes_i (sent_bytes_i),
    .grant_o      (grant_o),
    .round_done_o (round_done_o)
  );

  typedef struct {
    logic [RINGS-1:0] grant;
    logic             done;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;

  // Bench-side model of the requirements.
  int w[RINGS];
  int m_left[RINGS];
  int m_ptr;
  bit m_act;

  task automatic step(input logic [1:0] md, input logic [RINGS-1:0] rq,
                      input bit sv, input int nb, input string tag);
    exp_t e;
    int   g;
    @(negedge clk);
    mode_i       = md;
    req_i        = rq;
    sent_valid_i = sv;
    sent_bytes_i = BW'(nb);
    for (int i = 0; i < RINGS; i++) weight_i[i*WW +: WW] = WW'(w[i]);
    g = -1;
    if (md == WM) begin
      for (int i = RINGS - 1; i >= m_ptr; i--)
        if (rq[i] && w[i] != 0 && m_left[i] > 0) g = i;
    end else begin
      for (int i = RINGS - 1; i >= 0; i--)
        if (rq[i]) g = i;
    end
    e.grant = (g >= 0) ? (RINGS'(1) << g) : '0;
    e.done  = (md == WM) && (g < 0) && m_act;
    e.tag   = tag;
    sb.push_back(e);
    if (md != WM || g < 0) begin
      for (int i = 0; i < RINGS; i++) m_left[i] = w[i] * 64;
      m_ptr = 0;
      m_act = 0;
    end else begin
      if (sv) m_left[g] = (nb >= m_left[g]) ? 0 : m_left[g] - nb;
      m_ptr = g;
      m_act = 1;
    end
  endtask

  // Monitor: compares outputs between clock edges.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (grant_o !== e.grant || round_done_o !== e.done) begin
          fails++;
          $display("FAIL %s: grant=%b done=%b expected grant=%b done=%b",
                   e.tag, grant_o, round_done_o, e.grant, e.done);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RINGS; i++) begin
      w[i] = 0;
      m_left[i] = 0;
    end
    m_ptr = 0;
    m_act = 0;
    req_i = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (grant_o !== '0 || round_done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: grant=%b done=%b expected grant=%b done=0",
               grant_o, round_done_o, 8'h00);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Fixed-priority modes
    step(2'b00, 8'hA4, 0, 0, "R2 mode00 lowest of 10100100");
    step(2'b01, 8'h80, 0, 0, "R2 mode01 only ring7");
    step(2'b11, 8'h00, 0, 0, "R7 nothing requested");
    step(2'b00, 8'h01, 0, 0, "R2 weights ignored (ring0 weight 0)");

    // Weighted rounds: ring0=1, ring2=2, ring7=1, others 0
    w[0] = 1; w[2] = 2; w[7] = 1;
    step(WM, 8'hFF, 0, 0,    "R6 first weighted cycle refills, no pulse");
    step(WM, 8'hFF, 1, 100,  "R3 ring0 granted, frame overshoots");
    step(WM, 8'hFF, 1, 64,   "R8 ring2 has its own full quota");
    step(WM, 8'hFF, 0, 0,    "R3 ring2 holds without report");
    step(WM, 8'hFF, 1, 64,   "R3 ring2 last frame");
    step(WM, 8'hFF, 1, 10,   "R4 zero-weight rings skipped, ring7");
    step(WM, 8'hFF, 1, 1500, "R3 large frame on ring7");
    step(WM, 8'hFF, 0, 0,    "R6 round end pulse");
    step(WM, 8'hFF, 1, 30,   "R6 quotas refilled, ring0 again");
    step(WM, 8'hFE, 0, 0,    "R5 ring0 drops request, grant moves on");
    step(WM, 8'hFF, 1, 200,  "R5 ring0 not regranted in round");
    step(WM, 8'hFF, 0, 0,    "R5 ascending to ring7");
    step(WM, 8'h7F, 0, 0,    "R6 ring7 drops, round closes");
    step(WM, 8'hFF, 1, 64,   "R6 new round from ring0");
    step(2'b00, 8'hFF, 0, 0, "R9 leave weighted mode");
    step(WM, 8'hFF, 1, 10,   "R9 fresh round from ring0 without pulse");
    step(WM, 8'hFF, 0, 0,    "R3 ring0 keeps grant with quota left");
    for (int i = 0; i < RINGS; i++) w[i] = 0;
    step(WM, 8'hFF, 0, 0,    "R4 all weights zero closes round");
    step(WM, 8'hFF, 0, 0,    "R7 idle weighted cycle, no grant no pulse");

    @(negedge clk);
    #3;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule